// File: doc/BRIEF.md
# Packet Data Pointer with Auto-Increment

This block sits between a host's data-port accesses and a packet buffer RAM. The host first programs a 16-bit pointer word. That word holds three things: a byte offset inside a packet, a bit that chooses between the receive area and the transmit area, and a bit that gives the direction of the data accesses that follow. A separate host-written register holds a transmit packet number. On every data access the block drives a RAM address. The upper part of that address is the packet number and the lower part is the byte offset.

When auto-increment is enabled, each accepted access advances the offset by the width of the access: one, two or four bytes. The offset wraps inside the packet and never carries into the packet number. In the receive area the packet number is the current head of the receive queue. In the transmit area it is the programmed register.

When a pointer write selects reads, the block starts a fixed-length prefetch. During the prefetch a ready flag stays low, and the bus must hold off until the flag returns.

Top module: `pkt_ptr_unit`

## Requirements
- R1: After reset the pointer readback is 0, the packet-number register is 0, `rd_ready` is 1 and `ram_addr` is 0.
- R2: When pointer bit 15 is 1, the packet-number part of `ram_addr` equals `rxq_head`. When bit 15 is 0, it equals the last value written through `pnr_wr`.
- R3: `ram_addr` is `{packet number, offset}`, where the offset is pointer bits 10:0 and `ram_addr` is PN_W+11 bits wide.
- R4: When pointer bit 14 is 1, an accepted access advances the offset by `1 << min(acc_size,2)`. `acc_size` is 0 for a byte, 1 for a word, and 2 or 3 for a double word. When bit 14 is 0, the offset does not change.
- R5: The offset wraps modulo 2048 and the packet-number part of the address is unaffected by the wrap.
- R6: `acc_is_read` equals pointer bit 13: 1 means reads, 0 means writes.
- R7: A pointer write with bit 13 set drives `rd_ready` low for exactly PREFETCH_CYC cycles. A pointer write with bit 13 clear leaves `rd_ready` high.
- R8: An access made while `rd_ready` is low is not accepted, and the offset does not move.
- R9: When a pointer write and an access fall in the same cycle, the access uses the old address, no increment takes place, and the pointer takes the written value.
- R10: Pointer readback bits 12:11 always read 0, whatever value was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ptr_wr | input | 1 | Pointer write strobe |
| ptr_wdata | input | 16 | Pointer write value |
| pnr_wr | input | 1 | Packet-number register write strobe |
| pnr_wdata | input | PN_W | Packet-number write value |
| rxq_head | input | PN_W | Packet number at the head of the receive queue |
| acc_valid | input | 1 | Data access strobe, one per access |
| acc_size | input | 2 | Access width: 0 byte, 1 word, 2 or 3 double word |
| ram_addr | output | PN_W+11 | RAM byte address for the current access |
| acc_is_read | output | 1 | Direction of the data accesses |
| rd_ready | output | 1 | Low while a read prefetch is in progress |
| ptr_rdata | output | 16 | Pointer readback |

## Verification
The assertions assume that `acc_valid` is a single-cycle strobe for each access and that `rxq_head` is stable while the receive area is selected. They also assume the host does not depend on an access being accepted while `rd_ready` is low. The stimulus drives every input at a point away from the clock edge. It changes `rxq_head` only between accesses, and it waits for `rd_ready` after read-direction pointer writes. The one exception is the case that deliberately tests an access during the busy window.

// File: rtl/pkt_ptr_pkg.sv
package pkt_ptr_pkg;
  localparam int PTR_W    = 16;
  localparam int OFF_W    = 11;
  localparam int RCV_BIT  = 15;
  localparam int INC_BIT  = 14;
  localparam int DIR_BIT  = 13;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_DWALT = 2'd3
  } acc_size_e;

  function automatic logic [OFF_W-1:0] step_of(input logic [1:0] sz);
    logic [OFF_W-1:0] s;
    case (sz)
      SZ_BYTE: s = OFF_W'(1);
      SZ_WORD: s = OFF_W'(2);
      default: s = OFF_W'(4);
    endcase
    return s;
  endfunction
endpackage

// File: rtl/ptr_reg_file.sv
module ptr_reg_file
  import pkt_ptr_pkg::*;
#(
  parameter int PN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_wr,
  input  logic             wr_rcv,
  input  logic             wr_inc,
  input  logic             wr_dir,
  input  logic [OFF_W-1:0] wr_off,
  input  logic             pnr_wr,
  input  logic [PN_W-1:0]  pnr_wdata,
  input  logic             adv,
  input  logic [1:0]       adv_size,
  output logic             rcv_q,
  output logic             inc_q,
  output logic             dir_q,
  output logic [OFF_W-1:0] off_q,
  output logic [PN_W-1:0]  pnr_q
);
  logic             rcv_d, inc_d, dir_d;
  logic [OFF_W-1:0] off_d;
  logic [PN_W-1:0]  pnr_d;

  always_comb begin
    rcv_d = rcv_q;
    inc_d = inc_q;
    dir_d = dir_q;
    off_d = off_q;
    if (ptr_wr) begin
      rcv_d = wr_rcv;
      inc_d = wr_inc;
      dir_d = wr_dir;
      off_d = wr_off;
    end else if (adv) begin
      off_d = off_q + step_of(adv_size);
    end
    pnr_d = pnr_wr ? pnr_wdata : pnr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcv_q <= 1'b0;
      inc_q <= 1'b0;
      dir_q <= 1'b0;
      off_q <= '0;
      pnr_q <= '0;
    end else begin
      rcv_q <= rcv_d;
      inc_q <= inc_d;
      dir_q <= dir_d;
      off_q <= off_d;
      pnr_q <= pnr_d;
    end
  end
endmodule

// File: rtl/prefetch_ctl.sv
module prefetch_ctl #(
  parameter int PREFETCH_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ptr_wr,
  input  logic wr_dir,
  output logic ready
);
  localparam int CW = $clog2(PREFETCH_CYC + 2);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ptr_wr)             cnt_d = wr_dir ? CW'(PREFETCH_CYC) : '0;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ready = (cnt_q == '0);
endmodule

// File: rtl/addr_former.sv
module addr_former
  import pkt_ptr_pkg::*;
#(
  parameter int PN_W = 6
) (
  input  logic                  rcv,
  input  logic [PN_W-1:0]       rxq_head,
  input  logic [PN_W-1:0]       pnr,
  input  logic [OFF_W-1:0]      off,
  output logic [PN_W+OFF_W-1:0] addr
);
  logic [PN_W-1:0] pkt;
  assign pkt  = rcv ? rxq_head : pnr;
  assign addr = {pkt, off};
endmodule

// File: rtl/pkt_ptr_unit.sv
module pkt_ptr_unit
  import pkt_ptr_pkg::*;
#(
  parameter int PN_W         = 6,
  parameter int PREFETCH_CYC = 3,
  localparam int ADDR_W      = PN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_wr,
  input  logic [PTR_W-1:0]  ptr_wdata,
  input  logic              pnr_wr,
  input  logic [PN_W-1:0]   pnr_wdata,
  input  logic [PN_W-1:0]   rxq_head,
  input  logic              acc_valid,
  input  logic [1:0]        acc_size,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              acc_is_read,
  output logic              rd_ready,
  output logic [PTR_W-1:0]  ptr_rdata
);
  localparam int RSVD_W = DIR_BIT - OFF_W;

  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic             rcv_q, inc_q, dir_q;
  logic [OFF_W-1:0] off_q;
  logic [PN_W-1:0]  pnr_q;
  logic             adv;
  logic             unused_rsvd;

  assign unused_rsvd = ^ptr_wdata[DIR_BIT-1:OFF_W];
  assign adv = acc_valid & rd_ready & inc_q & ~ptr_wr;

  ptr_reg_file #(.PN_W(PN_W)) u_regs (
    .clk(clk), .rst_n(rst_q),
    .ptr_wr(ptr_wr),
    .wr_rcv(ptr_wdata[RCV_BIT]), .wr_inc(ptr_wdata[INC_BIT]),
    .wr_dir(ptr_wdata[DIR_BIT]), .wr_off(ptr_wdata[OFF_W-1:0]),
    .pnr_wr(pnr_wr), .pnr_wdata(pnr_wdata),
    .adv(adv), .adv_size(acc_size),
    .rcv_q(rcv_q), .inc_q(inc_q), .dir_q(dir_q), .off_q(off_q), .pnr_q(pnr_q)
  );

  prefetch_ctl #(.PREFETCH_CYC(PREFETCH_CYC)) u_pf (
    .clk(clk), .rst_n(rst_q), .ptr_wr(ptr_wr),
    .wr_dir(ptr_wdata[DIR_BIT]), .ready(rd_ready)
  );

  addr_former #(.PN_W(PN_W)) u_addr (
    .rcv(rcv_q), .rxq_head(rxq_head), .pnr(pnr_q), .off(off_q), .addr(ram_addr)
  );

  assign acc_is_read = dir_q;
  assign ptr_rdata   = {rcv_q, inc_q, dir_q, {RSVD_W{1'b0}}, off_q};
endmodule

// File: rtl/pkt_ptr_chk.sv
module pkt_ptr_chk
  import pkt_ptr_pkg::*;
#(
  parameter int PN_W         = 6,
  parameter int PREFETCH_CYC = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ptr_wr,
  input logic [PTR_W-1:0]      ptr_wdata,
  input logic                  acc_valid,
  input logic [1:0]            acc_size,
  input logic [PN_W-1:0]       rxq_head,
  input logic [PN_W+OFF_W-1:0] ram_addr,
  input logic                  acc_is_read,
  input logic                  rd_ready,
  input logic [PTR_W-1:0]      ptr_rdata
);
  localparam logic [PTR_W-1:0] KEEP_MASK = ~(PTR_W'((1 << DIR_BIT) - (1 << OFF_W)));

  AST_RX_PKT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rdata[RCV_BIT] |-> ram_addr[PN_W+OFF_W-1:OFF_W] == rxq_head); // R2
  AST_OFF_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ram_addr[OFF_W-1:0] == ptr_rdata[OFF_W-1:0]); // R3
  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && rd_ready && ptr_rdata[INC_BIT] && !ptr_wr && acc_size == 2'd0)
      |=> ptr_rdata[OFF_W-1:0] == $past(ptr_rdata[OFF_W-1:0]) + OFF_W'(1)); // R4
  AST_NO_INC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !ptr_rdata[INC_BIT] && !ptr_wr) |=> $stable(ptr_rdata)); // R4
  AST_DIR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_is_read == ptr_rdata[DIR_BIT]); // R6
  AST_READ_PREFETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wr && ptr_wdata[DIR_BIT]) |=> !rd_ready); // R7
  AST_WRITE_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wr && !ptr_wdata[DIR_BIT]) |=> rd_ready); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !rd_ready && !ptr_wr) |=> $stable(ptr_rdata)); // R8
  AST_PTRWR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> ptr_rdata == ($past(ptr_wdata) & KEEP_MASK)); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rdata[DIR_BIT-1:OFF_W] == '0); // R10
endmodule

bind pkt_ptr_unit pkt_ptr_chk #(.PN_W(PN_W), .PREFETCH_CYC(PREFETCH_CYC)) u_chk (
  .clk(clk), .rst_n(rst_q), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
  .acc_valid(acc_valid), .acc_size(acc_size), .rxq_head(rxq_head),
  .ram_addr(ram_addr), .acc_is_read(acc_is_read), .rd_ready(rd_ready),
  .ptr_rdata(ptr_rdata)
);

// File: tb/tb_pkt_ptr_unit.sv
module tb_pkt_ptr_unit;
  localparam int PN_W = 6;
  localparam int PF   = 3;
  localparam int AW   = PN_W + 11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ptr_wr = 1'b0;
  logic [15:0]     ptr_wdata = '0;
  logic            pnr_wr = 1'b0;
  logic [PN_W-1:0] pnr_wdata = '0;
  logic [PN_W-1:0] rxq_head = '0;
  logic            acc_valid = 1'b0;
  logic [1:0]      acc_size = '0;
  logic [AW-1:0]   ram_addr;
  logic            acc_is_read, rd_ready;
  logic [15:0]     ptr_rdata;

  pkt_ptr_unit #(.PN_W(PN_W), .PREFETCH_CYC(PF)) dut (.*);

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  logic [AW-1:0] exp_q[$];
  string         tag_q[$];

  logic            m_rcv = 0, m_inc = 0, m_dir = 0;
  logic [10:0]     m_off = '0;
  logic [PN_W-1:0] m_pnr = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] m_addr();
    return {m_rcv ? rxq_head : m_pnr, m_off};
  endfunction

  function automatic logic [15:0] m_ptr();
    return {m_rcv, m_inc, m_dir, 2'b00, m_off};
  endfunction

  // monitor: compares each access address against the scoreboard
  always @(negedge clk) begin
    #2;
    if (acc_valid) begin
      if (exp_q.size() == 0) check("SCOREBOARD", 32'd1, 32'd0);
      else check(tag_q.pop_front(), 32'(ram_addr), 32'(exp_q.pop_front()));
    end
  end

  task automatic wr_pnr(input logic [PN_W-1:0] v);
    pnr_wr = 1; pnr_wdata = v;
    @(negedge clk); pnr_wr = 0;
    m_pnr = v;
  endtask

  task automatic wr_ptr(input logic [15:0] v);
    ptr_wr = 1; ptr_wdata = v;
    @(negedge clk); #1; ptr_wr = 0;
    m_rcv = v[15]; m_inc = v[14]; m_dir = v[13]; m_off = v[10:0];
  endtask

  task automatic wait_ready(input string req, input int exp_n);
    int n = 0;
    while (!rd_ready && n < 50) begin @(negedge clk); #1; n++; end
    check(req, 32'(n), 32'(exp_n));
  endtask

  // driver: one access, expected address pushed to the scoreboard
  task automatic access(input string req, input logic [1:0] sz, input logic accepted);
    acc_valid = 1; acc_size = sz;
    exp_q.push_back(m_addr()); tag_q.push_back(req);
    @(negedge clk); #1; acc_valid = 0;
    if (accepted && m_inc) m_off = m_off + ((sz == 0) ? 11'd1 : (sz == 1) ? 11'd2 : 11'd4);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk); #1;
    check("R1 ptr", 32'(ptr_rdata), 32'h0);
    check("R1 ready", 32'(rd_ready), 32'h1);
    check("R1 addr", 32'(ram_addr), 32'h0);

    // transmit area, write direction, auto-increment; reserved bits written as 1
    wr_pnr(6'h05);
    wr_ptr(16'h4000 | 16'h1800 | 16'h010);
    check("R10 rsvd", 32'(ptr_rdata), 32'(m_ptr()));
    check("R7 write dir ready", 32'(rd_ready), 32'h1);
    check("R6 write dir", 32'(acc_is_read), 32'h0);
    access("R3 byte", 2'd0, 1);
    access("R4 word", 2'd1, 1);
    access("R4 dword", 2'd2, 1);
    access("R4 size3", 2'd3, 1);
    access("R2 pnr sel", 2'd0, 1);
    check("R4 ptr after", 32'(ptr_rdata), 32'(m_ptr()));

    // receive area, read direction, wrap near the end
    rxq_head = 6'h2A;
    wr_ptr(16'hE000 | 16'h7FE);
    wait_ready("R7 prefetch len", PF);
    check("R6 read dir", 32'(acc_is_read), 32'h1);
    access("R2 rx head", 2'd1, 1);
    access("R5 wrap", 2'd2, 1);
    check("R5 off wrapped", 32'(ptr_rdata), 32'(m_ptr()));
    rxq_head = 6'h11;
    access("R2 rx head change", 2'd0, 1);

    // auto-increment off
    wr_ptr(16'h0100);
    access("R4 no inc a", 2'd2, 1);
    access("R4 no inc b", 2'd1, 1);
    check("R4 no inc ptr", 32'(ptr_rdata), 32'(m_ptr()));

    // access during prefetch is not accepted
    wr_ptr(16'h6040);
    access("R8 busy access", 2'd1, 0);
    check("R8 off held", 32'(ptr_rdata), 32'(m_ptr()));
    wait_ready("R8 ready return", PF - 1);
    access("R8 after ready", 2'd1, 1);
    check("R8 advanced", 32'(ptr_rdata), 32'(m_ptr()));

    // simultaneous pointer write and access
    wr_ptr(16'h4020);
    ptr_wr = 1; ptr_wdata = 16'h4333; acc_valid = 1; acc_size = 2'd2;
    exp_q.push_back(m_addr()); tag_q.push_back("R9 old addr");
    @(negedge clk); #1; ptr_wr = 0; acc_valid = 0;
    m_off = 11'h333;
    check("R9 ptr wins", 32'(ptr_rdata), 32'(m_ptr()));
    check("R7 ready stays", 32'(rd_ready), 32'h1);

    repeat (2) @(negedge clk);
    check("SCOREBOARD drained", 32'(exp_q.size()), 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule